// File: doc/BRIEF.md
# Flash Byte Access Port

This block lets a host move single bytes to and from an external parallel flash or boot ROM through one 32-bit control/status word. To start an operation the host writes that word once. The word carries a 17-bit byte address, an 8-bit data byte and one of two command bits, one for reading and one for writing. The block then runs the flash pins through a fixed sequence of four states. In IDLE every pin is inactive. SETUP is one clock with chip select low and the address valid. STROBE holds the output-enable or write-enable strobe low for a number of clocks the host can set. HOLD is one clock with the strobe released and chip select still low, after which the block returns to IDLE.

The block signals completion by clearing the command bit in hardware. When a read completes, the data field holds the byte taken from the flash, which was latched on the last clock of the strobe. The host polls the word until both command bits read zero. While an operation is in progress the block ignores host writes.

The transitions are as follows. IDLE goes to SETUP when a command bit is set. SETUP always goes to STROBE. STROBE goes to HOLD once its counter reaches the wait count latched at the start of the operation. HOLD always goes to IDLE and clears the command bits.

Top module: `flash_byte_port`

## Requirements
- R1: After reset the status word reads zero, chip select, output enable and write enable are high (inactive), and the data bus output enable is low.
- R2: Layout of the status word: bit 27 is the write command, bit 26 is the read command, bits 24..8 are the byte address and bits 7..0 are the data byte. Bits 31..28 and bit 25 always read zero. The flash address pins always show the address field.
- R3: When a host write sets bit 27, the data byte is written to the flash at the address, and bit 27 reads zero once the operation has finished.
- R4: When a host write sets bit 26 (with bit 27 clear), the block reads the byte at the address into bits 7..0, and bit 26 reads zero once the operation has finished.
- R5: When a host write sets both bit 26 and bit 27, the block performs a write only, and bit 26 reads zero.
- R6: Host writes made while bit 26 or bit 27 is set are ignored. They change neither the fields of the word nor the flash contents.
- R7: Each operation lowers chip select for one setup clock, then holds the strobe low for cfg_wait+1 clocks, then keeps chip select low for one more hold clock. A command bit therefore reads zero cfg_wait+4 clocks after the clock edge that accepted the host write.
- R8: The data bus output enable is high only during the strobe of a write.
- R9: A host write with bits 26 and 27 both clear only loads the address and data fields, and chip select stays high.
- R10: The two strobes are never low together, and neither strobe is low unless chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe for the status word |
| host_wdata | input | 32 | Word written by the host |
| cfg_wait | input | 4 | Strobe wait states; the strobe lasts cfg_wait+1 clocks |
| csr_rdata | output | 32 | Current value of the status word |
| fl_addr | output | 17 | Flash byte address |
| fl_dq_out | output | 8 | Data driven to the flash |
| fl_dq_oe | output | 1 | Enable for the flash data bus driver |
| fl_dq_in | input | 8 | Data returned by the flash |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output enable (read strobe), active low |
| fl_we_n | output | 1 | Flash write enable (write strobe), active low |

## Verification
Random reads and writes at random addresses, with random data and random wait counts, are compared against a reference copy of the memory. This separates a correctly addressed transfer from one that lands on the wrong byte or latches stale data. For every operation the bench measures the completion time and the number of strobe and chip-select clocks, so an error of one clock in any state shows up. Directed cases cover the extreme wait counts, a word with both command bits set, a word with neither bit set, a host write during an operation, and a word with every bit set, which shows the reserved bits and the address width.

// File: rtl/flash_port_pkg.sv
package flash_port_pkg;
    localparam int unsigned CSR_W   = 32;
    localparam int unsigned ADDR_W  = 17;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned WAIT_W  = 4;
    localparam int unsigned ADDR_LO = 8;
    localparam int unsigned ADDR_HI = ADDR_LO + ADDR_W - 1;
    localparam int unsigned RD_BIT  = 26;
    localparam int unsigned WR_BIT  = 27;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/fbp_csr.sv
module fbp_csr
    import flash_port_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [CSR_W-1:0] host_wdata,
    input  logic             cap_rd,
    input  logic [DW-1:0]    rd_byte,
    input  logic             done,
    output logic [AW-1:0]    addr_q,
    output logic [DW-1:0]    data_q,
    output logic             ren_q,
    output logic             wen_q
);
    logic busy;
    logic accept;

    assign busy   = ren_q | wen_q;
    assign accept = host_wr & ~busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            ren_q  <= 1'b0;
            wen_q  <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= host_wdata[ADDR_LO +: AW];
                data_q <= host_wdata[DW-1:0];
                wen_q  <= host_wdata[WR_BIT];
                ren_q  <= host_wdata[RD_BIT] & ~host_wdata[WR_BIT];
            end else if (done) begin
                ren_q <= 1'b0;
                wen_q <= 1'b0;
            end
            if (cap_rd) begin
                data_q <= rd_byte;
            end
        end
    end

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr) |=> $stable(addr_q)) else $error("host write accepted while busy"); // R6
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !(ren_q || wen_q)) else $error("command bit not cleared"); // R3
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && host_wdata[WR_BIT]) |=> !ren_q) else $error("read kept with write"); // R5
endmodule

// File: rtl/fbp_seq.sv
module fbp_seq
    import flash_port_pkg::*;
#(
    parameter int unsigned WW = WAIT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren,
    input  logic          wen,
    input  logic [WW-1:0] cfg_wait,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n,
    output logic          fl_dq_oe,
    output logic          cap_rd,
    output logic          done
);
    seq_state_t    state_q, state_d;
    logic [WW-1:0] cnt_q;
    logic [WW-1:0] wait_q;
    logic          is_wr_q;
    logic          strobe_last;

    assign strobe_last = (cnt_q == wait_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ren || wen) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (strobe_last) state_d = ST_HOLD;
            ST_HOLD:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wait_q  <= '0;
            is_wr_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_SETUP) begin
                wait_q  <= cfg_wait;
                is_wr_q <= wen;
            end
            if (state_q == ST_STROBE) cnt_q <= cnt_q + 1'b1;
            else                      cnt_q <= '0;
        end
    end

    always_comb begin
        fl_ce_n  = 1'b1;
        fl_oe_n  = 1'b1;
        fl_we_n  = 1'b1;
        fl_dq_oe = 1'b0;
        cap_rd   = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SETUP: fl_ce_n = 1'b0;
            ST_STROBE: begin
                fl_ce_n  = 1'b0;
                fl_oe_n  = is_wr_q;
                fl_we_n  = ~is_wr_q;
                fl_dq_oe = is_wr_q;
                cap_rd   = ~is_wr_q & strobe_last;
            end
            ST_HOLD: begin
                fl_ce_n = 1'b0;
                done    = 1'b1;
            end
            default: ;
        endcase
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_oe_n && !fl_we_n)) else $error("both strobes low"); // R10
    AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_oe_n || !fl_we_n) |-> !fl_ce_n) else $error("strobe without select"); // R10
    AST_DQ_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        fl_dq_oe |-> !fl_we_n) else $error("bus driven outside write strobe"); // R8
    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_ce_n) |-> (fl_oe_n && fl_we_n)) else $error("no setup clock"); // R7
    AST_HOLD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_ce_n) |-> $past(fl_oe_n && fl_we_n)) else $error("no hold clock"); // R7
endmodule

// File: rtl/flash_byte_port.sv
module flash_byte_port
    import flash_port_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned WW = WAIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [CSR_W-1:0] host_wdata,
    input  logic [WW-1:0]    cfg_wait,
    output logic [CSR_W-1:0] csr_rdata,
    output logic [AW-1:0]    fl_addr,
    output logic [DW-1:0]    fl_dq_out,
    output logic             fl_dq_oe,
    input  logic [DW-1:0]    fl_dq_in,
    output logic             fl_ce_n,
    output logic             fl_oe_n,
    output logic             fl_we_n
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          ren_q, wen_q, cap_rd, done;

    fbp_csr #(.AW(AW), .DW(DW)) u_csr (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .cap_rd(cap_rd), .rd_byte(fl_dq_in), .done(done),
        .addr_q(addr_q), .data_q(data_q), .ren_q(ren_q), .wen_q(wen_q)
    );

    fbp_seq #(.WW(WW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ren(ren_q), .wen(wen_q), .cfg_wait(cfg_wait),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
        .fl_dq_oe(fl_dq_oe), .cap_rd(cap_rd), .done(done)
    );

    always_comb begin
        csr_rdata                 = '0;
        csr_rdata[WR_BIT]         = wen_q;
        csr_rdata[RD_BIT]         = ren_q;
        csr_rdata[ADDR_LO +: AW]  = addr_q;
        csr_rdata[DW-1:0]         = data_q;
    end

    assign fl_addr   = addr_q;
    assign fl_dq_out = data_q;
endmodule

// File: tb/tb_flash_byte_port.sv
module tb_flash_byte_port;
    localparam int CLK_NS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  cfg_wait = '0;
    logic [31:0] csr_rdata;
    logic [16:0] fl_addr;
    logic [7:0]  fl_dq_out, fl_dq_in;
    logic        fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0] mem [0:1023];
    logic [7:0] ref_mem [0:1023];

    int strobe_cnt, ce_cnt, dq_bad, both_low;

    always #(CLK_NS/2.0) clk = ~clk;

    flash_byte_port dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .cfg_wait(cfg_wait), .csr_rdata(csr_rdata), .fl_addr(fl_addr),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    assign fl_dq_in = (!fl_ce_n && !fl_oe_n) ? mem[fl_addr[9:0]] : 8'h00;

    always @(posedge clk)
        if (!fl_ce_n && !fl_we_n) mem[fl_addr[9:0]] <= fl_dq_out;

    always @(negedge clk) begin
        if (!fl_oe_n || !fl_we_n) strobe_cnt++;
        if (!fl_ce_n) ce_cnt++;
        if (fl_dq_oe && fl_we_n) dq_bad++;
        if (!fl_oe_n && !fl_we_n) both_low++;
    end

    function automatic logic [31:0] mk_word(logic wen, logic ren, logic [16:0] a, logic [7:0] d);
        return {4'h0, wen, ren, 1'b0, a, d};
    endfunction

    function automatic int exp_cycles(int w);
        return w + 4;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(logic [31:0] w);
        @(negedge clk);
        host_wr = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // runs one command, returns clocks until both command bits clear
    task automatic run_op(logic [31:0] w, logic [3:0] ws, output int n);
        cfg_wait = ws;
        strobe_cnt = 0; ce_cnt = 0; dq_bad = 0; both_low = 0;
        host_write(w);
        n = 0;
        while (csr_rdata[27] || csr_rdata[26]) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic timing_checks(int n, int ws);
        check("R7 busy clocks", n, exp_cycles(ws));
        check("R7 strobe clocks", strobe_cnt, ws + 1);
        check("R7 select clocks", ce_cnt, ws + 3);
        check("R10 strobes together", both_low, 0);
        check("R8 bus driven outside write strobe", dq_bad, 0);
    endtask

    task automatic do_write(logic [16:0] a, logic [7:0] d, logic [3:0] ws, logic also_rd);
        int n;
        run_op(mk_word(1'b1, also_rd, a, d), ws, n);
        ref_mem[a[9:0]] = d;
        timing_checks(n, ws);
        check("R3 flash byte written", mem[a[9:0]], ref_mem[a[9:0]]);
        check("R3 word after write", csr_rdata, mk_word(1'b0, 1'b0, a, d));
    endtask

    task automatic do_read(logic [16:0] a, logic [3:0] ws);
        int n;
        run_op(mk_word(1'b0, 1'b1, a, 8'h00), ws, n);
        timing_checks(n, ws);
        check("R4 read byte", csr_rdata, mk_word(1'b0, 1'b0, a, ref_mem[a[9:0]]));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        #(CLK_NS * 3);
        @(negedge clk);
        check("R1 word at reset", csr_rdata, 32'h0);
        check("R1 pins at reset", {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
        rst_n = 1'b1;

        // R2: every bit set except the commands
        host_write(32'hF3FF_FFFF);
        check("R2 reserved bits zero", csr_rdata, 32'h01FF_FFFF);
        check("R2 address pins", fl_addr, 17'h1FFFF);

        // R9: no command -> no flash cycle
        ce_cnt = 0;
        host_write(mk_word(1'b0, 1'b0, 17'h00155, 8'hA5));
        repeat (5) @(negedge clk);
        check("R9 select stays high", ce_cnt, 0);
        check("R9 fields loaded", csr_rdata, mk_word(1'b0, 1'b0, 17'h00155, 8'hA5));

        // R7 extremes
        do_write(17'h00010, 8'h5A, 4'd0, 1'b0);
        do_read(17'h00010, 4'd0);
        do_write(17'h1F3FF, 8'hC3, 4'd15, 1'b0);
        do_read(17'h1F3FF, 4'd15);

        // R5: both bits -> write only
        do_write(17'h00222, 8'h99, 4'd2, 1'b1);

        // R6: host write during an operation
        cfg_wait = 4'd6;
        strobe_cnt = 0; ce_cnt = 0; dq_bad = 0; both_low = 0;
        host_write(mk_word(1'b1, 1'b0, 17'h00033, 8'h3C));
        ref_mem[10'h033] = 8'h3C;
        host_write(mk_word(1'b1, 1'b0, 17'h00044, 8'hEE));
        n = 2;
        while (csr_rdata[27] || csr_rdata[26]) begin
            @(negedge clk);
            n++;
        end
        check("R6 busy write ignored fields", csr_rdata, mk_word(1'b0, 1'b0, 17'h00033, 8'h3C));
        check("R6 flash untouched", mem[10'h044], ref_mem[10'h044]);
        check("R6 first write done", mem[10'h033], 8'h3C);
        check("R6 single operation", strobe_cnt, 7);

        // constrained random mix
        for (int k = 0; k < 40; k++) begin
            logic [16:0] a;
            logic [7:0]  d;
            logic [3:0]  ws;
            a  = 17'($urandom);
            d  = 8'($urandom);
            ws = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 1) do_write(a, d, ws, 1'b0);
            else                           do_read(a, ws);
        end

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule